// File: doc/BRIEF.md
# Five-Port XY Mesh Switch with Stuck-Port Fault Injection

This block is the switching element of a two-dimensional mesh network. It has four neighbour ports (East, South, West, North) and one port to the local processing element. Each packet travels as a train of flits with a single header flit at its front. The header holds the destination column and row. The switch sends the packet along the column axis until the column matches, then along the row axis. It delivers the packet locally when both coordinates match its own position, which is set by parameters.

Each input holds a wormhole path to one output from the moment its header wins that output until its tail flit has been handed over. Contention between inputs for the same output is resolved by a rotating priority.

A fault-select input makes the switch misbehave in a controlled way. While a stuck-port mode is selected, every new packet goes to the one chosen output whatever its destination says. This lets detection logic elsewhere in the mesh be exercised against realistic routing faults. The mode is read only when a header is granted, so a packet already in flight stays on one output.

Top module: `mesh_router`

## Requirements
- R1: After reset no output presents a valid flit, and no input asserts ready while it offers nothing.
- R2: With fault_sel = 0, a header whose destination column (bits [COORD_W-1:0] of the flit) is greater than MY_X leaves on East, port code 1 (out index 0). A column less than MY_X leaves on West, code 3 (index 2).
- R3: With fault_sel = 0 and a matching column, a destination row (bits [2*COORD_W-1:COORD_W]) greater than MY_Y leaves on North, code 4 (index 3). A smaller row leaves on South, code 2 (index 1).
- R4: With fault_sel = 0, a destination equal to (MY_X, MY_Y) leaves on the Processor port, code 5 (index 4).
- R5: fault_sel values 1 to 5 send every new packet to the port of that code (out index fault_sel-1), ignoring the destination. Values 0, 6 and 7 mean fault-free routing.
- R6: fault_sel is sampled only in the cycle a header is granted. Changing it while a packet is in flight does not move the rest of that packet.
- R7: Once granted, an output carries only its owning input's flits until that input's tail flit (bit FLIT_W-2 set) is transferred. A competing header stays not-ready meanwhile.
- R8: A free output grants the first requesting input found by searching upward, with wrap-around, from the input after the last one it granted. The search starts at input 0 after reset.
- R9: A header is granted in the cycle it is first presented and forwarded from the next cycle. While locked, an input's ready equals the ready of its output, and its flits appear on that output in the same cycle.
- R10: A flit without the header bit (bit FLIT_W-1) arriving on an input that holds no path is accepted and dropped, and appears on no output.
- R11: A single flit with both header and tail bits set forms a complete packet and releases its output after one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_sel | input | 3 | 0 fault-free, 1..5 force all packets to that port code, 6..7 fault-free |
| in_valid | input | 5 | Per-input flit valid, index = port code - 1 |
| in_ready | output | 5 | Per-input flit accepted |
| in_data | input | 5*FLIT_W | Per-input flit: [FLIT_W-1] header, [FLIT_W-2] tail, low bits payload |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_data | output | 5*FLIT_W | Per-output flit |

## Verification
On every cycle, assertions check several properties. A busy output is always mirrored by a lock on exactly its owning input. A tail transfer frees the output on the next edge, and without one the owner cannot change. Every grant made under a stuck-port mode lands on the selected port. Each input's route decode names exactly one port. What the assertions cannot see is whether the chosen port is the right one for a given destination, or whether the rotating priority picks inputs in the right order. The bench settles these by sweeping every input, every destination of a small mesh and every fault code, plus directed sequences for contention, backpressure, mid-packet mode changes and stray body flits.

// File: rtl/mr_pkg.sv
package mr_pkg;
    localparam int NPORTS      = 5;
    localparam int PORT_IDX_W  = 3;

    typedef enum logic [2:0] {
        PC_NONE  = 3'd0,
        PC_EAST  = 3'd1,
        PC_SOUTH = 3'd2,
        PC_WEST  = 3'd3,
        PC_NORTH = 3'd4,
        PC_PROC  = 3'd5
    } port_code_e;
endpackage

// File: rtl/mr_route_calc.sv
module mr_route_calc
    import mr_pkg::*;
#(
    parameter int COORD_W = 2,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 1
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [2:0]         fault_sel,
    output logic [NPORTS-1:0]  port_oh
);
    localparam logic [COORD_W-1:0] HERE_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(MY_Y);

    port_code_e code_d;

    always_comb begin
        if (fault_sel >= 3'd1 && fault_sel <= 3'd5) begin
            code_d = port_code_e'(fault_sel);      // forced stuck port
        end else if (dst_x > HERE_X) begin
            code_d = PC_EAST;
        end else if (dst_x < HERE_X) begin
            code_d = PC_WEST;
        end else if (dst_y > HERE_Y) begin
            code_d = PC_NORTH;
        end else if (dst_y < HERE_Y) begin
            code_d = PC_SOUTH;
        end else begin
            code_d = PC_PROC;
        end
        port_oh = '0;
        port_oh[int'(code_d) - 1] = 1'b1;
    end
endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!gnt_any && req[j]) begin
                gnt_idx = IDX_W'(j);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mr_pkg::*;
#(
    parameter  int COORD_W = 2,
    parameter  int DATA_W  = 8,
    parameter  int MY_X    = 2,
    parameter  int MY_Y    = 1,
    localparam int FLIT_W  = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               fault_sel,
    input  logic [NPORTS-1:0]        in_valid,
    output logic [NPORTS-1:0]        in_ready,
    input  logic [NPORTS*FLIT_W-1:0] in_data,
    output logic [NPORTS-1:0]        out_valid,
    input  logic [NPORTS-1:0]        out_ready,
    output logic [NPORTS*FLIT_W-1:0] out_data
);
    localparam int IDX_W   = PORT_IDX_W;
    localparam int HEAD_B  = FLIT_W - 1;
    localparam int TAIL_B  = FLIT_W - 2;

    typedef struct packed {
        logic [NPORTS-1:0]            locked;
        logic [NPORTS-1:0][IDX_W-1:0] dir;
        logic [NPORTS-1:0]            busy;
        logic [NPORTS-1:0][IDX_W-1:0] owner;
        logic [NPORTS-1:0][IDX_W-1:0] ptr;
    } sw_state_t;

    sw_state_t st_d, st_q;

    logic [NPORTS-1:0][FLIT_W-1:0] flit;
    logic [NPORTS-1:0][FLIT_W-1:0] out_flit;
    logic [NPORTS-1:0]             is_head, is_tail;
    logic [NPORTS-1:0][NPORTS-1:0] route_oh;   // [input][output]
    logic [NPORTS-1:0][NPORTS-1:0] req_to;     // [output][input]
    logic [NPORTS-1:0][IDX_W-1:0]  gnt_idx;
    logic [NPORTS-1:0]             gnt_any;

    assign flit     = in_data;
    assign out_data = out_flit;

    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            is_head[i] = flit[i][HEAD_B];
            is_tail[i] = flit[i][TAIL_B];
        end
    end

    // Route decode per input, with fault override
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_route
        mr_route_calc #(
            .COORD_W(COORD_W),
            .MY_X   (MY_X),
            .MY_Y   (MY_Y)
        ) u_rt (
            .dst_x    (flit[gi][COORD_W-1:0]),
            .dst_y    (flit[gi][2*COORD_W-1:COORD_W]),
            .fault_sel(fault_sel),
            .port_oh  (route_oh[gi])
        );

        AST_ROUTE_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(route_oh[gi]) == 1)
            else $error("route decode not one-hot"); // R2
    end

    // Header requests, transposed into per-output vectors
    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            for (int i = 0; i < NPORTS; i++) begin
                req_to[o][i] = in_valid[i] && is_head[i] && !st_q.locked[i]
                               && route_oh[i][o];
            end
        end
    end

    for (genvar go = 0; go < NPORTS; go++) begin : g_arb
        mr_rr_arb #(
            .N    (NPORTS),
            .IDX_W(IDX_W)
        ) u_arb (
            .req    (req_to[go] & {NPORTS{~st_q.busy[go]}}),
            .ptr    (st_q.ptr[go]),
            .gnt_idx(gnt_idx[go]),
            .gnt_any(gnt_any[go])
        );
    end

    // Datapath: outputs follow their owner; inputs follow their locked output
    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            out_valid[o] = st_q.busy[o] && in_valid[st_q.owner[o]];
            out_flit[o]  = flit[st_q.owner[o]];
        end
        for (int i = 0; i < NPORTS; i++) begin
            if (st_q.locked[i]) begin
                in_ready[i] = out_ready[st_q.dir[i]];
            end else begin
                in_ready[i] = in_valid[i] && !is_head[i];   // stray body flit: drop
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NPORTS; o++) begin
            if (st_q.busy[o]) begin
                if (out_valid[o] && out_ready[o] && is_tail[st_q.owner[o]]) begin
                    st_d.busy[o]               = 1'b0;
                    st_d.locked[st_q.owner[o]] = 1'b0;
                end
            end else if (gnt_any[o]) begin
                st_d.busy[o]               = 1'b1;
                st_d.owner[o]              = gnt_idx[o];
                st_d.ptr[o]                = (gnt_idx[o] == IDX_W'(NPORTS - 1)) ?
                                             '0 : gnt_idx[o] + 1'b1;
                st_d.locked[gnt_idx[o]]    = 1'b1;
                st_d.dir[gnt_idx[o]]       = IDX_W'(o);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar go = 0; go < NPORTS; go++) begin : g_chk
        AST_OWNER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.busy[go] |-> (st_q.locked[st_q.owner[go]] &&
                               st_q.dir[st_q.owner[go]] == IDX_W'(go)))
            else $error("busy output without matching input lock"); // R7

        AST_TAIL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy[go] && out_valid[go] && out_ready[go] && is_tail[st_q.owner[go]])
            |=> !st_q.busy[go])
            else $error("output not freed after tail"); // R7

        AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy[go] && !(out_valid[go] && out_ready[go] && is_tail[st_q.owner[go]]))
            |=> (st_q.busy[go] && $stable(st_q.owner[go])))
            else $error("path changed mid-packet"); // R6

        AST_FAULT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_any[go] && fault_sel >= 3'd1 && fault_sel <= 3'd5)
            |-> (fault_sel == 3'(go + 1)))
            else $error("grant off the stuck port"); // R5
    end
endmodule

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
    localparam int NP  = 5;
    localparam int FW  = 10;
    localparam int MYX = 2;
    localparam int MYY = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      fault_sel = '0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP-1:0]   in_ready;
    logic [NP*FW-1:0] in_data = '0;
    logic [NP-1:0]   out_valid;
    logic [NP-1:0]   out_ready = '1;
    logic [NP*FW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mesh_router #(.COORD_W(2), .DATA_W(8), .MY_X(MYX), .MY_Y(MYY)) u0 (
        .clk(clk), .rst_n(rst_n), .fault_sel(fault_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [FW-1:0] mk(bit h, bit t, int tag, int dy, int dx);
        return {h, t, 4'(tag), 2'(dy), 2'(dx)};
    endfunction

    // Expected output index from the requirements
    function automatic int exp_idx(int dx, int dy, int f);
        if (f >= 1 && f <= 5) return f - 1;   // R5
        if (dx > MYX) return 0;               // R2 East
        if (dx < MYX) return 2;               // R2 West
        if (dy > MYY) return 3;               // R3 North
        if (dy < MYY) return 1;               // R3 South
        return 4;                             // R4 Processor
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drv(int i, bit v, logic [FW-1:0] f);
        in_valid[i] = v;
        in_data[i*FW +: FW] = f;
    endtask

    // port < 0: no output may be valid
    task automatic expect_out(int port, logic [FW-1:0] f, string req);
        bit ok = 1'b1;
        for (int o = 0; o < NP; o++) begin
            if (o == port) begin
                if (!out_valid[o] || out_data[o*FW +: FW] !== f) ok = 1'b0;
            end else if (out_valid[o]) begin
                ok = 1'b0;
            end
        end
        chk(ok, req, {17'd0, out_valid, (port >= 0) ? out_data[port*FW +: FW] : 10'd0},
            {17'd0, (port >= 0) ? 5'(1 << port) : 5'd0, f});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = '0;
        in_data = '0;
        out_ready = '1;
        fault_sel = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(int i, int dx, int dy, int f, string req);
        int ep = exp_idx(dx, dy, f);
        logic [FW-1:0] h = mk(1, 0, i + 3, dy, dx);
        logic [FW-1:0] t = mk(0, 1, 9, dy, dx);
        @(negedge clk);
        fault_sel = 3'(f);
        drv(i, 1, h);
        #1 expect_out(-1, '0, "R9");
        @(negedge clk);
        #1 expect_out(ep, h, req);
        chk(in_ready[i] == 1'b1, "R9", {31'd0, in_ready[i]}, 32'd1);
        @(negedge clk);
        drv(i, 1, t);
        #1 expect_out(ep, t, "R7");
        @(negedge clk);
        drv(i, 0, '0);
        #1 expect_out(-1, '0, "R7");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: quiet after reset
        #1 chk(out_valid == '0, "R1", {27'd0, out_valid}, 32'd0);
        chk(in_ready == '0, "R1", {27'd0, in_ready}, 32'd0);

        // Sweep: every input, destination and fault code (R2 R3 R4 R5)
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < NP; i++) begin
                for (int dx = 0; dx < 4; dx++) begin
                    for (int dy = 0; dy < 4; dy++) begin
                        string rq;
                        if (f >= 1) rq = "R5";
                        else if (dx != MYX) rq = "R2";
                        else if (dy != MYY) rq = "R3";
                        else rq = "R4";
                        send(i, dx, dy, f, rq);
                    end
                end
            end
        end

        // R9: backpressure while locked
        do_reset();
        @(negedge clk);
        drv(4, 1, mk(1, 0, 5, 0, 3));
        @(negedge clk);
        out_ready[0] = 1'b0;
        #1 chk(in_ready[4] == 1'b0, "R9", {31'd0, in_ready[4]}, 32'd0);
        expect_out(0, mk(1, 0, 5, 0, 3), "R9");
        @(negedge clk);
        #1 expect_out(0, mk(1, 0, 5, 0, 3), "R9");
        out_ready[0] = 1'b1;
        #1 chk(in_ready[4] == 1'b1, "R9", {31'd0, in_ready[4]}, 32'd1);
        @(negedge clk);
        drv(4, 1, mk(0, 1, 6, 0, 3));
        #1 expect_out(0, mk(0, 1, 6, 0, 3), "R9");
        @(negedge clk);
        drv(4, 0, '0);

        // R6: fault mode changes mid-packet; tail stays on West
        @(negedge clk);
        fault_sel = 3'd0;
        drv(1, 1, mk(1, 0, 7, 1, 0));
        @(negedge clk);
        #1 expect_out(2, mk(1, 0, 7, 1, 0), "R6");
        @(negedge clk);
        fault_sel = 3'd5;
        drv(1, 1, mk(0, 1, 8, 1, 0));
        #1 expect_out(2, mk(0, 1, 8, 1, 0), "R6");
        @(negedge clk);
        drv(1, 0, '0);
        send(1, 0, 1, 5, "R6");   // next packet takes the new mode

        // R7: wormhole lock against a competing header
        do_reset();
        @(negedge clk);
        fault_sel = 3'd5;
        drv(0, 1, mk(1, 0, 1, 0, 0));
        drv(1, 1, mk(1, 1, 2, 0, 0));
        #1 expect_out(-1, '0, "R7");
        @(negedge clk);
        #1 expect_out(4, mk(1, 0, 1, 0, 0), "R7");
        chk(in_ready[1] == 1'b0, "R7", {31'd0, in_ready[1]}, 32'd0);
        @(negedge clk);
        drv(0, 1, mk(0, 0, 3, 0, 0));
        #1 expect_out(4, mk(0, 0, 3, 0, 0), "R7");
        chk(in_ready[1] == 1'b0, "R7", {31'd0, in_ready[1]}, 32'd0);
        @(negedge clk);
        drv(0, 1, mk(0, 1, 4, 0, 0));
        #1 expect_out(4, mk(0, 1, 4, 0, 0), "R7");
        @(negedge clk);
        drv(0, 0, '0);
        #1 expect_out(-1, '0, "R7");
        @(negedge clk);
        #1 expect_out(4, mk(1, 1, 2, 0, 0), "R11");
        chk(in_ready[1] == 1'b1, "R11", {31'd0, in_ready[1]}, 32'd1);
        @(negedge clk);
        drv(1, 0, '0);
        #1 expect_out(-1, '0, "R11");

        // R8: rotating priority, pointer now after input 1 -> order 3, 0, 1
        @(negedge clk);
        drv(0, 1, mk(1, 1, 10, 0, 0));
        drv(1, 1, mk(1, 1, 11, 0, 0));
        drv(3, 1, mk(1, 1, 13, 0, 0));
        @(negedge clk);
        #1 expect_out(4, mk(1, 1, 13, 0, 0), "R8");
        @(negedge clk);
        drv(3, 0, '0);
        @(negedge clk);
        #1 expect_out(4, mk(1, 1, 10, 0, 0), "R8");
        @(negedge clk);
        drv(0, 0, '0);
        @(negedge clk);
        #1 expect_out(4, mk(1, 1, 11, 0, 0), "R8");
        @(negedge clk);
        drv(1, 0, '0);
        #1 expect_out(-1, '0, "R8");

        // R10: stray body flit on an idle input is dropped
        do_reset();
        @(negedge clk);
        drv(2, 1, mk(0, 1, 12, 0, 3));
        #1 chk(in_ready[2] == 1'b1, "R10", {31'd0, in_ready[2]}, 32'd1);
        expect_out(-1, '0, "R10");
        @(negedge clk);
        drv(2, 0, '0);
        #1 expect_out(-1, '0, "R10");
        send(2, 3, 0, 0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule